// File: doc/BRIEF.md
# Auto Transmit/Receive GPIO Controller

This block drives one 16-bit general-purpose I/O bank toward a daughter card. Each bit has its own output enable. Each bit also chooses its driven value from one of two places. One is a manual output register that software writes. The other is a pair of preset patterns that switch automatically with transmit activity.

A transmit-activity input tells the block that the transmit FIFO is not empty. The block turns that input into a T/R state. The T/R state rises only after a programmable number of clock ticks, and it falls only after a second, separately programmable number of ticks. The T/R state, not the raw activity flag, decides whether the transmit pattern or the receive pattern reaches the automatically controlled bits.

Software reaches the block through a single register write port that carries a value and a per-bit mask. A combinational read port returns the live pin value. A global enable bit turns automatic switching off for the whole bank.

Top module: `atr_gpio_ctrl`

## Requirements
- R1: After reset, all five bank registers, both delay counts and the control bit are zero. `tr_out` is low, `pin_oe` is 0 and `pin_out` is 0.
- R2: A write to a bank register (select 0 direction, 1 manual output, 2 auto-select, 3 transmit pattern, 4 receive pattern) changes only the bits whose `wr_mask` bit is 1. The other bits keep their old value. The new value is visible on the outputs one clock after the write edge.
- R3: `pin_oe` equals the direction register. A 1 makes that bit an output toward the card and a 0 leaves it an input.
- R4: While the control enable is 1, a bit whose auto-select bit is 1 drives the transmit pattern bit when `tr_out` is high and the receive pattern bit when it is low. A bit whose auto-select bit is 0 drives the manual output bit.
- R5: While the control enable is 0, every bit of `pin_out` equals the manual output register, whatever the auto-select bits, the patterns or `tr_out` are.
- R6: With rise delay D, `tr_out` goes high at the (D+1)th consecutive rising clock edge that samples `tx_busy` high. If `tx_busy` drops earlier, the rise is cancelled.
- R7: With fall delay F, `tr_out` goes low at the (F+1)th consecutive rising clock edge that samples `tx_busy` low.
- R8: If `tx_busy` returns high while a fall delay is counting, `tr_out` stays high on every cycle and does not glitch.
- R9: While a rise delay is still counting, the auto-selected bits keep driving the receive pattern, even though `tx_busy` is already high.
- R10: `rd_pins` returns `pin_out` on bits whose direction bit is 1, and `pin_in` resynchronised through two flops on bits whose direction bit is 0.
- R11: Select 5 loads the rise delay and select 6 loads the fall delay, each from the low DLY_W bits of `wr_data`. Select 7 loads the control enable from bit 0 of `wr_data`. These three selects ignore `wr_mask`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select |
| wr_data | input | 16 | Write value |
| wr_mask | input | 16 | Per-bit write mask for the bank registers |
| tx_busy | input | 1 | Transmit FIFO not empty |
| pin_in | input | 16 | Pin levels seen from the card |
| pin_out | output | 16 | Driven pin values |
| pin_oe | output | 16 | Per-bit output enable |
| rd_pins | output | 16 | Live pin read value |
| tr_out | output | 1 | Delayed T/R state |

## Verification
Two events can land on the same clock edge: a register write to the auto-select register or to a pattern register, and a change of the T/R state. Both change `pin_out`, so a defect in either one can hide behind the other.

The random phase keeps both delays at zero, so T/R follows `tx_busy` with a lag of one edge. It then changes `tx_busy` and issues a masked write in the same cycle. One cycle later, `pin_out` must match a value that the bench computes from the updated register image and the new T/R level together. The directed cases then stretch the delays to check the exact edge on which T/R changes, and to check what the pins drive while a delay is still counting.

// File: rtl/atr_gpio_ctrl.sv
module atr_gpio_ctrl #(
  parameter int WIDTH = 16,
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [2:0]       wr_sel,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [WIDTH-1:0] wr_mask,
  input  logic             tx_busy,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_oe,
  output logic [WIDTH-1:0] rd_pins,
  output logic             tr_out
);
  localparam logic [2:0] SEL_OE = 3'd0, SEL_IO = 3'd1, SEL_MASK = 3'd2,
                         SEL_TXV = 3'd3, SEL_RXV = 3'd4, SEL_RISE = 3'd5,
                         SEL_FALL = 3'd6, SEL_CTRL = 3'd7;

  logic [WIDTH-1:0] oe_q, io_q, mask_q, txv_q, rxv_q;
  logic [DLY_W-1:0] rise_q, fall_q, cnt_q;
  logic             en_q, tr_q;
  logic [WIDTH-1:0] sync1_q, sync2_q;

  function automatic logic [WIDTH-1:0] merge(input logic [WIDTH-1:0] old_v);
    return (old_v & ~wr_mask) | (wr_data & wr_mask);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_q <= '0; io_q <= '0; mask_q <= '0; txv_q <= '0; rxv_q <= '0;
      rise_q <= '0; fall_q <= '0; en_q <= 1'b0;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_OE:   oe_q   <= merge(oe_q);
        SEL_IO:   io_q   <= merge(io_q);
        SEL_MASK: mask_q <= merge(mask_q);
        SEL_TXV:  txv_q  <= merge(txv_q);
        SEL_RXV:  rxv_q  <= merge(rxv_q);
        SEL_RISE: rise_q <= wr_data[DLY_W-1:0];
        SEL_FALL: fall_q <= wr_data[DLY_W-1:0];
        SEL_CTRL: en_q   <= wr_data[0];
        default:  ;
      endcase
    end
  end

  // T/R shaping: the counter runs only while tx_busy disagrees with tr_q
  logic             want_change;
  logic [DLY_W-1:0] limit;
  assign want_change = tx_busy ^ tr_q;
  assign limit       = tr_q ? fall_q : rise_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tr_q  <= 1'b0;
      cnt_q <= '0;
    end else if (!want_change) begin
      cnt_q <= '0;
    end else if (cnt_q >= limit) begin
      tr_q  <= ~tr_q;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
    end
  end

  logic [WIDTH-1:0] pattern, auto_bits;
  assign pattern   = tr_q ? txv_q : rxv_q;
  assign auto_bits = en_q ? mask_q : '0;
  assign pin_out   = (pattern & auto_bits) | (io_q & ~auto_bits);
  assign pin_oe    = oe_q;
  assign rd_pins   = (pin_out & oe_q) | (sync2_q & ~oe_q);
  assign tr_out    = tr_q;

  a_r2_mask_keeps_oe: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == SEL_OE) |=> ((oe_q ^ $past(oe_q)) & ~$past(wr_mask)) == '0);
  a_r2_mask_keeps_io: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == SEL_IO) |=> ((io_q ^ $past(io_q)) & ~$past(wr_mask)) == '0);
  a_r6_rise_needs_busy: assert property (@(posedge clk) disable iff (rst)
    $rose(tr_out) |-> $past(tx_busy));
  a_r7_fall_needs_idle: assert property (@(posedge clk) disable iff (rst)
    $fell(tr_out) |-> !$past(tx_busy));
  a_r8_busy_holds_tr: assert property (@(posedge clk) disable iff (rst)
    (tr_out && tx_busy) |=> tr_out);
  a_r3_oe_stable_no_write: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_sel == SEL_OE) |=> $stable(pin_oe));
endmodule

// File: tb/tb_atr_gpio_ctrl.sv
module tb_atr_gpio_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [15:0] wr_data = '0, wr_mask = '0, pin_in = '0;
  logic        tx_busy = 1'b0;
  logic [15:0] pin_out, pin_oe, rd_pins;
  logic        tr_out;

  int checks = 0, errors = 0;
  logic [15:0] m_oe = 0, m_io = 0, m_mask = 0, m_tx = 0, m_rx = 0;
  logic        m_en = 0;

  atr_gpio_ctrl dut (.clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .wr_mask(wr_mask), .tx_busy(tx_busy), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .rd_pins(rd_pins), .tr_out(tr_out));

  always #4 clk = ~clk;

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic logic [15:0] exp_out(input logic tr);
    logic [15:0] a;
    a = m_en ? m_mask : 16'h0;
    return ((tr ? m_tx : m_rx) & a) | (m_io & ~a);
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mg(input logic [15:0] o, input logic [15:0] d, input logic [15:0] m);
    return (o & ~m) | (d & m);
  endfunction

  // drives at negedge; update model; registers visible at following negedge
  task automatic put(input logic [2:0] s, input logic [15:0] d, input logic [15:0] m);
    wr_en = 1; wr_sel = s; wr_data = d; wr_mask = m;
    case (s)
      3'd0: m_oe = mg(m_oe, d, m);
      3'd1: m_io = mg(m_io, d, m);
      3'd2: m_mask = mg(m_mask, d, m);
      3'd3: m_tx = mg(m_tx, d, m);
      3'd4: m_rx = mg(m_rx, d, m);
      3'd7: m_en = d[0];
      default: ;
    endcase
  endtask

  task automatic wr(input logic [2:0] s, input logic [15:0] d, input logic [15:0] m);
    put(s, d, m);
    @(negedge clk);
    wr_en = 0;
  endtask

  initial begin
    int n;
    logic ok;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 pin_out", pin_out, 16'h0);
    chk("R1 pin_oe", pin_oe, 16'h0);
    chk("R1 tr_out", {15'h0, tr_out}, 16'h0);

    // R11: write delays ignoring mask (mask zero); verified by timing below
    // Random phase: delays zero, tr follows busy one edge later (R2 R3 R4 R5)
    for (int i = 0; i < 300; i++) begin
      logic [2:0] s;
      logic b;
      s = 3'($urandom_range(0, 5));
      if (s == 3'd5) s = 3'd7;
      b = 1'($urandom);
      tx_busy = b;
      put(s, 16'($urandom), 16'($urandom));
      @(negedge clk);
      wr_en = 0;
      chk(m_en ? "R2 R4 pin_out" : "R2 R5 pin_out", pin_out, exp_out(b));
      chk("R2 R3 pin_oe", pin_oe, m_oe);
    end

    // R5 directed: disabled with everything else set
    tx_busy = 1;
    wr(3'd7, 16'h0, 16'h0);
    wr(3'd2, 16'hFFFF, 16'hFFFF);
    wr(3'd1, 16'h3C3C, 16'hFFFF);
    wr(3'd3, 16'hA5A5, 16'hFFFF);
    chk("R5 disabled", pin_out, 16'h3C3C);

    // R6 R9 R11 rise delay 3, masked write mask 0 must still load
    tx_busy = 0;
    wr(3'd4, 16'h5A5A, 16'hFFFF);
    wr(3'd7, 16'h1, 16'h0);
    wr(3'd5, 16'h3, 16'h0);
    wr(3'd6, 16'h2, 16'h0);
    repeat (5) @(negedge clk);
    chk("R6 idle tr", {15'h0, tr_out}, 16'h0);
    chk("R4 idle rx pattern", pin_out, 16'h5A5A);
    // cancel: busy for 2 edges only
    tx_busy = 1;
    repeat (2) @(negedge clk);
    chk("R9 rx during rise delay", pin_out, 16'h5A5A);
    tx_busy = 0;
    ok = 1;
    repeat (6) begin @(negedge clk); if (tr_out) ok = 0; end
    chk("R6 cancelled rise", {15'h0, ok}, 16'h1);
    // full rise
    tx_busy = 1;
    n = 0;
    while (!tr_out && n < 20) begin @(negedge clk); n++; end
    chk("R6 R11 rise edge count", 16'(n), 16'd4);
    chk("R4 tx pattern", pin_out, 16'hA5A5);
    // R8 glitch-free retrigger during fall
    repeat (2) @(negedge clk);
    tx_busy = 0;
    repeat (2) @(negedge clk);
    tx_busy = 1;
    ok = 1;
    repeat (6) begin @(negedge clk); if (!tr_out) ok = 0; end
    chk("R8 tr held", {15'h0, ok}, 16'h1);
    // R7 fall delay 2
    tx_busy = 0;
    n = 0;
    while (tr_out && n < 20) begin @(negedge clk); n++; end
    chk("R7 R11 fall edge count", 16'(n), 16'd3);
    chk("R4 back to rx", pin_out, 16'h5A5A);

    // R10 read port
    wr(3'd7, 16'h0, 16'h0);
    wr(3'd0, 16'hFF00, 16'hFFFF);
    wr(3'd1, 16'h1234, 16'hFFFF);
    pin_in = 16'hABCD;
    @(negedge clk);
    @(negedge clk);
    chk("R10 rd_pins", rd_pins, 16'h12CD);
    pin_in = 16'h0F0F;
    @(negedge clk);
    chk("R10 sync lag", rd_pins, 16'h12CD);
    @(negedge clk);
    chk("R10 rd_pins new", rd_pins, 16'h120F);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule